// File: doc/BRIEF.md
# All-Digital First-Order Phase-Locked Loop Core

This core closes a first-order phase-locked loop without analog parts. Two phase comparators watch a reference phase and a feedback phase: a registered exclusive-OR comparator, and an edge-triggered comparator that is set by a reference rising edge and cleared by a feedback rising edge. A select input routes one comparator output to the direction input of an up/down loop counter. The loop counter's length comes from a 4-bit code. When it wraps, it emits a carry or a borrow, and the pulse shaping stage uses that to add or remove a half-cycle in its output. That output is a divided-by-two copy of the pulse clock.

All timing runs on one system clock. The loop-counter clock and the pulse clock enter as one-cycle strobes. The divide-by-N counter that turns the output into the feedback phase sits outside the core. Software or a supervising state machine may change the length code at any time, which trades capture range against jitter while the loop runs.

Top module: `dpll_core`

## Requirements
- R1: After the asynchronous active-low reset, `xor_pd_o`, `edge_pd_o` and `id_o` are 0 and the loop counter holds 0.
- R2: `xor_pd_o` equals `ref_i ^ fb_i` as sampled on the previous clock edge.
- R3: `edge_pd_o` goes to 1 after a clock edge that sees `ref_i` rise without `fb_i` rising. It goes to 0 after an edge that sees `fb_i` rise without `ref_i` rising. If both rise at the same edge, it holds its value.
- R4: `dir_sel_i` = 0 routes `xor_pd_o` to the counter direction, and `dir_sel_i` = 1 routes `edge_pd_o`. A routed value of 1 means count down and 0 means count up.
- R5: When `len_code_i` is 0, the loop counter does not move and emits no carry or borrow.
- R6: A nonzero code L gives a counter of L+2 bits. Counting up from 0, it emits a carry on every 2^(L+2)-th step and wraps to 0.
- R7: Counting down, the counter emits a borrow on the step that leaves 0 and reloads the all-ones value of its current length. A carry and a borrow never occur in the same cycle.
- R8: With no carry or borrow pending, `id_o` toggles once for each cycle with `id_tick_i` high and holds otherwise.
- R9: A carry adds one extra toggle of `id_o` in the first following cycle without `id_tick_i`. A borrow removes the toggle of the next `id_tick_i`. Over a settled window, the toggle count equals pulse ticks plus carries minus borrows.
- R10: After a change of `len_code_i`, the counter continues from its value masked to the new length.
- R11: With `ctr_en_i` low, the loop counter holds its value and emits no carry or borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference phase |
| fb_i | input | 1 | Feedback phase from the external divider |
| k_tick_i | input | 1 | Loop-counter step strobe |
| id_tick_i | input | 1 | Pulse-clock strobe |
| ctr_en_i | input | 1 | Loop-counter enable |
| len_code_i | input | 4 | Counter length code, 0 disables |
| dir_sel_i | input | 1 | Comparator select: 0 exclusive-OR, 1 edge |
| xor_pd_o | output | 1 | Exclusive-OR comparator output |
| edge_pd_o | output | 1 | Edge comparator output |
| id_o | output | 1 | Shaped pulse output |

## Verification
The hardest case to reach from the ports is a carry or a borrow that changes the output count. Neither is visible directly. Each one shows up only as one toggle more or one toggle fewer on `id_o`, and that toggle can come several cycles after the counter step that caused it. The stimulus therefore holds each comparator in a known state and steps the counter in windows. Each window ends with a quiet tail, so every pending correction has landed before the toggles are counted. A reference model of the counter follows length changes, enable gaps and both direction sources and predicts how many carries and borrows each window produces.

// File: rtl/dpll_pkg.sv
`timescale 1ns/1ps
package dpll_pkg;
  parameter int CODE_W = 4;
  localparam int MAX_STAGES = (1 << CODE_W) + 1;
endpackage

// File: rtl/dpll_phase_det.sv
`timescale 1ns/1ps
module dpll_phase_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic xor_pd_o,
  output logic edge_pd_o
);
  logic ref_q, fb_q, xor_q, edge_q;
  logic ref_rise, fb_rise;

  // edge history; no reset needed, outputs are reset
  always_ff @(posedge clk_i) begin
    ref_q <= ref_i;
    fb_q  <= fb_i;
  end

  assign ref_rise = ref_i & ~ref_q;
  assign fb_rise  = fb_i & ~fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xor_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      xor_q <= ref_i ^ fb_i;
      if (ref_rise && !fb_rise)      edge_q <= 1'b1;
      else if (fb_rise && !ref_rise) edge_q <= 1'b0;
    end
  end

  assign xor_pd_o  = xor_q;
  assign edge_pd_o = edge_q;
endmodule

// File: rtl/dpll_kcounter.sv
`timescale 1ns/1ps
module dpll_kcounter #(
  parameter int CODE_W = dpll_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              down_i,
  output logic              carry_o,
  output logic              borrow_o
);
  localparam int STG = (1 << CODE_W) + 1;
  localparam int SHW = CODE_W + 1;

  logic [STG-1:0] cnt_q, cnt_d, mask, eff;
  logic [SHW-1:0] sh;
  logic           step, carry_d, borrow_d, carry_q, borrow_q;

  always_comb begin
    sh   = SHW'(STG - 2) - SHW'(code_i);
    mask = {STG{1'b1}} >> sh;
    eff  = cnt_q & mask;              // shorter code: drop upper stages
    step = tick_i & en_i & (code_i != '0);
    cnt_d    = cnt_q;
    carry_d  = 1'b0;
    borrow_d = 1'b0;
    if (step) begin
      if (down_i) begin
        if (eff == '0) begin
          cnt_d    = mask;
          borrow_d = 1'b1;
        end else begin
          cnt_d = eff - STG'(1);
        end
      end else begin
        if (eff == mask) begin
          cnt_d   = '0;
          carry_d = 1'b1;
        end else begin
          cnt_d = eff + STG'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
    end
  end

  assign carry_o  = carry_q;
  assign borrow_o = borrow_q;
endmodule

// File: rtl/dpll_incdec.sv
`timescale 1ns/1ps
module dpll_incdec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic id_tick_i,
  input  logic carry_i,
  input  logic borrow_i,
  output logic id_o
);
  logic carry_pend_q, borrow_pend_q, out_q;
  logic cp, bp, cp_d, bp_d, flip;

  always_comb begin
    cp   = carry_pend_q | carry_i;
    bp   = borrow_pend_q | borrow_i;
    cp_d = cp;
    bp_d = bp;
    flip = id_tick_i;
    if (cp && bp) begin
      cp_d = 1'b0;                    // corrections cancel
      bp_d = 1'b0;
    end else if (cp && !id_tick_i) begin
      flip = 1'b1;                    // insert half-cycle between ticks
      cp_d = 1'b0;
    end else if (bp && id_tick_i) begin
      flip = 1'b0;                    // swallow this tick
      bp_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_pend_q  <= 1'b0;
      borrow_pend_q <= 1'b0;
      out_q         <= 1'b0;
    end else begin
      carry_pend_q  <= cp_d;
      borrow_pend_q <= bp_d;
      out_q         <= out_q ^ flip;
    end
  end

  assign id_o = out_q;
endmodule

// File: rtl/dpll_core.sv
`timescale 1ns/1ps
module dpll_core #(
  parameter int CODE_W = dpll_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              fb_i,
  input  logic              k_tick_i,
  input  logic              id_tick_i,
  input  logic              ctr_en_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              dir_sel_i,
  output logic              xor_pd_o,
  output logic              edge_pd_o,
  output logic              id_o
);
  logic count_down, carry, borrow;

  dpll_phase_det i_pd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_i     (ref_i),
    .fb_i      (fb_i),
    .xor_pd_o  (xor_pd_o),
    .edge_pd_o (edge_pd_o)
  );

  assign count_down = dir_sel_i ? edge_pd_o : xor_pd_o;

  dpll_kcounter #(.CODE_W(CODE_W)) i_kcnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (k_tick_i),
    .en_i     (ctr_en_i),
    .code_i   (len_code_i),
    .down_i   (count_down),
    .carry_o  (carry),
    .borrow_o (borrow)
  );

  dpll_incdec i_incdec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_tick_i (id_tick_i),
    .carry_i   (carry),
    .borrow_i  (borrow),
    .id_o      (id_o)
  );
endmodule

// File: rtl/dpll_core_chk.sv
`timescale 1ns/1ps
module dpll_core_chk #(
  parameter int CODE_W = dpll_pkg::CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_i,
  input logic              fb_i,
  input logic              id_tick_i,
  input logic [CODE_W-1:0] len_code_i,
  input logic              ctr_en_i,
  input logic              xor_pd_o,
  input logic              edge_pd_o,
  input logic              id_o,
  input logic              carry,
  input logic              borrow,
  input logic              carry_pend,
  input logic              borrow_pend
);
  p_xor_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (xor_pd_o == $past(ref_i ^ fb_i)));

  p_edge_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_i) && !$rose(fb_i)) |=> edge_pd_o);

  p_edge_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fb_i) && !$rose(ref_i)) |=> !edge_pd_o);

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_code_i == '0) |=> (!carry && !borrow));

  p_hold_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctr_en_i |=> (!carry && !borrow));

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(carry && borrow));

  p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_tick_i && !carry && !carry_pend) |=> $stable(id_o));

  p_tick_swallow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_tick_i && borrow_pend && !borrow && !carry && !carry_pend) |=> $stable(id_o));
endmodule

bind dpll_core dpll_core_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_i       (ref_i),
  .fb_i        (fb_i),
  .id_tick_i   (id_tick_i),
  .len_code_i  (len_code_i),
  .ctr_en_i    (ctr_en_i),
  .xor_pd_o    (xor_pd_o),
  .edge_pd_o   (edge_pd_o),
  .id_o        (id_o),
  .carry       (carry),
  .borrow      (borrow),
  .carry_pend  (i_incdec.carry_pend_q),
  .borrow_pend (i_incdec.borrow_pend_q)
);

// File: tb/test_dpll_core.sv
`timescale 1ns/1ps
module test_dpll_core;
  logic       clk_i = 1'b0;
  logic       rst_ni, ref_i, fb_i, k_tick_i, id_tick_i, ctr_en_i, dir_sel_i;
  logic [3:0] len_code_i;
  logic       xor_pd_o, edge_pd_o, id_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dpll_core i_dpll_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .k_tick_i(k_tick_i), .id_tick_i(id_tick_i), .ctr_en_i(ctr_en_i),
    .len_code_i(len_code_i), .dir_sel_i(dir_sel_i),
    .xor_pd_o(xor_pd_o), .edge_pd_o(edge_pd_o), .id_o(id_o)
  );

  int    n_chk = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  event  win_ev;
  int    tog_total = 0;
  int    m_cnt = 0, m_code = 0;
  bit    m_en = 1'b1, m_dn = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: count id_o toggles, score each window against the queue
  initial begin
    logic prev;
    @(posedge rst_ni);
    prev = id_o;
    forever begin
      @(posedge clk_i);
      #1;
      if (id_o !== prev) tog_total++;
      prev = id_o;
    end
  end

  initial begin
    int last = 0;
    forever begin
      int    e, a;
      string t;
      @(win_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = tog_total - last;
      last = tog_total;
      chk(a == e, t, a, e);
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_phase(logic r, logic f);
    @(negedge clk_i);
    ref_i = r;
    fb_i  = f;
    wait_n(3);
  endtask

  // driver: step strobes, model the counter, push expected toggle count
  task automatic run_win(int n, string tag);
    int car = 0, bor = 0, idt = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      k_tick_i  = (c % 4 == 0) && (c < n - 8);
      id_tick_i = (c % 3 == 0);
      if (id_tick_i) idt++;
      if (k_tick_i && m_en && m_code != 0) begin
        int mask, e;
        mask = (1 << (m_code + 2)) - 1;
        e = m_cnt & mask;
        if (m_dn) begin
          if (e == 0) begin m_cnt = mask; bor++; end
          else m_cnt = e - 1;
        end else begin
          if (e == mask) begin m_cnt = 0; car++; end
          else m_cnt = e + 1;
        end
      end
    end
    @(negedge clk_i);
    k_tick_i  = 1'b0;
    id_tick_i = 1'b0;
    exp_q.push_back(idt + car - bor);
    tag_q.push_back(tag);
    -> win_ev;
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ref_i = 1'b0; fb_i = 1'b0; k_tick_i = 1'b0; id_tick_i = 1'b0;
    ctr_en_i = 1'b1; dir_sel_i = 1'b0; len_code_i = 4'd0;
    wait_n(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(xor_pd_o == 1'b0, "R1 xor after reset", int'(xor_pd_o), 0);
    chk(edge_pd_o == 1'b0, "R1 edge after reset", int'(edge_pd_o), 0);
    chk(id_o == 1'b0, "R1 id after reset", int'(id_o), 0);

    // R2 xor comparator
    ref_i = 1'b1;
    @(negedge clk_i);
    chk(xor_pd_o == 1'b1, "R2 xor 1^0", int'(xor_pd_o), 1);
    fb_i = 1'b1;
    @(negedge clk_i);
    chk(xor_pd_o == 1'b0, "R2 xor 1^1", int'(xor_pd_o), 0);
    chk(edge_pd_o == 1'b0, "R3 cleared by fb rise", int'(edge_pd_o), 0);

    // R3 edge comparator
    set_phase(1'b0, 1'b0);
    ref_i = 1'b1;
    @(negedge clk_i);
    chk(edge_pd_o == 1'b1, "R3 set by ref rise", int'(edge_pd_o), 1);
    set_phase(1'b0, 1'b0);
    ref_i = 1'b1; fb_i = 1'b1;
    @(negedge clk_i);
    chk(edge_pd_o == 1'b1, "R3 both rise holds 1", int'(edge_pd_o), 1);
    fb_i = 1'b0;
    wait_n(2);
    fb_i = 1'b1;
    @(negedge clk_i);
    chk(edge_pd_o == 1'b0, "R3 fb rise clears", int'(edge_pd_o), 0);
    set_phase(1'b0, 1'b0);
    ref_i = 1'b1; fb_i = 1'b1;
    @(negedge clk_i);
    chk(edge_pd_o == 1'b0, "R3 both rise holds 0", int'(edge_pd_o), 0);

    // R5 R8: disabled counter, plain divide by two
    set_phase(1'b1, 1'b0);
    len_code_i = 4'd0; m_code = 0; m_dn = 1'b1;
    run_win(200, "R5 R8 code 0 toggles");

    // R6 R9: shortest counter counting up
    set_phase(1'b0, 1'b0);
    len_code_i = 4'd1; m_code = 1; m_dn = 1'b0;
    run_win(200, "R6 R9 code 1 up carries");

    // R7 R9: counting down
    set_phase(1'b1, 1'b0);
    m_dn = 1'b1;
    run_win(200, "R7 R9 code 1 down borrows");

    // R4: edge comparator high while xor low
    set_phase(1'b0, 1'b1);
    set_phase(1'b1, 1'b1);
    chk(edge_pd_o == 1'b1 && xor_pd_o == 1'b0, "R4 setup edge=1 xor=0",
        int'({edge_pd_o, xor_pd_o}), 2);
    dir_sel_i = 1'b1; len_code_i = 4'd2; m_code = 2; m_dn = 1'b1;
    run_win(220, "R4 edge select counts down");
    dir_sel_i = 1'b0; m_dn = 1'b0;
    run_win(220, "R4 xor select counts up");

    // R6 R10: longer counter, then shorter code mid-run
    len_code_i = 4'd3; m_code = 3;
    run_win(100, "R6 code 3 up");
    len_code_i = 4'd1; m_code = 1;
    run_win(100, "R10 code shrink continues masked");

    // R11: enable low holds
    set_phase(1'b1, 1'b0);
    ctr_en_i = 1'b0; m_en = 1'b0; m_dn = 1'b1;
    run_win(200, "R11 enable low no corrections");
    ctr_en_i = 1'b1; m_en = 1'b1;
    run_win(200, "R11 resume from held value");

    // R6: longest counter
    set_phase(1'b0, 1'b0);
    len_code_i = 4'd15; m_code = 15; m_dn = 1'b0;
    run_win(200, "R6 code 15 up");

    wait_n(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule